// File: doc/BRIEF.md
# Half-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 16-bit binary floating-point numbers. Each word has a sign bit at bit 15, a 5-bit biased exponent in bits 14:10 with bias 15, and a 10-bit fraction in bits 9:0. A subtract request inverts the sign of the second operand, and the block then works on the effective operation. The block restores the implicit leading one of normal operands. It orders the two operands by magnitude and shifts the smaller significand right to line up the exponents. Every bit that the shift pushes out is kept in one guard bit, one round bit and one sticky bit. The block then adds or subtracts the magnitudes, normalizes the result, rounds it to nearest-even, and packs the result word again.

The work is split into two pipeline steps. The first step does the unpacking, operand ordering, alignment and the add or subtract. The second step does normalization, rounding, special-value selection and packing. The caller may present a new operand pair every cycle together with a valid strobe. The matching result appears with its own valid strobe two clock edges later.

Top module: `hp_addsub`

## Requirements
- R1: After reset `resValid` is 0 and `res` is 0x0000. A pair accepted with `inValid` high at one rising edge produces `resValid` high exactly two rising edges later, and never earlier.
- R2: When the effective signs match, the magnitudes add. A sum of 2.0 or more takes a single right shift and an exponent increment (0x3C00+0x3C00=0x4000, 0x3E00+0x3C00=0x4100).
- R3: When the effective signs differ, the result is shifted left until the leading one reaches the hidden position, and the exponent drops by one for each step (0x3C00−0x3BFF=0x1000).
- R4: The result is rounded to nearest using the guard, round and sticky bits. An exact tie rounds to the even fraction (0x3C00+0x1000=0x3C00, 0x3C01+0x1000=0x3C02).
- R5: When rounding carries out of the significand, the exponent goes up by one and the fraction becomes zero (0x3FFF+0x1000=0x4000).
- R6: A finite result whose exponent field would reach 31 becomes infinity with the sign of the result (0x7BFF+0x7BFF=0x7C00, 0xFBFF+0xFBFF=0xFC00).
- R7: A NaN operand (exponent 31, fraction nonzero) gives the quiet NaN 0x7E00. Subtracting two infinities of the same sign, or adding two infinities of opposite signs, also gives 0x7E00.
- R8: When exactly one operand is infinite, the result is that infinity with its effective sign (0x7C00+0x3C00=0x7C00, 0x3C00−0x7C00=0xFC00).
- R9: Exact cancellation of opposite-signed values gives +0 (0x0000). Adding two zeros of the same sign keeps that sign (0x8000+0x8000=0x8000).
- R10: An exponent field of 0 encodes a denormal: there is no hidden one and the scale is 2^−14. A result too small for a normal number comes out as a denormal, and the sum of two denormals can become normal (0x0001+0x0001=0x0002, 0x0400−0x0001=0x03FF, 0x0200+0x0200=0x0400).
- R11: When `subSel` is 1, the sign of `opB` is inverted before the operation (0x3C00 minus 0xBC00 = 0x4000).
- R12: The sign of a nonzero result of opposite-signed operands is the sign of the operand with the larger magnitude (0x3C00+0xC000=0xBC00).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Marks the operand pair as present this cycle |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| subSel | input | 1 | 1 = subtract opB from opA, 0 = add |
| resValid | output | 1 | Marks `res` as holding a new result |
| res | output | 16 | Packed result; it holds its value between valid cycles |

## Verification
The assertions take for granted that `inValid` is never unknown after reset. They also assume that `opA`, `opB` and `subSel` are known in any cycle where `inValid` is high, because the alignment-order and normalization checks only look at cycles where a step is enabled. The stimulus follows this rule. It holds `inValid` low through reset and drives known operands on every valid cycle. It streams operand pairs back to back, so both pipeline steps are busy at once. It also includes zeros, denormals, infinities and NaNs, so the special-value paths run through the same strobes.

// File: rtl/hp_addsub_pkg.sv
package hp_addsub_pkg;
  localparam int EXP_W   = 5;
  localparam int FRAC_W  = 10;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int SIG_W   = FRAC_W + 1;          // significand with hidden bit
  localparam int EXT_W   = SIG_W + 3;           // plus guard, round, sticky
  localparam int EXP_MAX = (1 << EXP_W) - 1;    // all-ones exponent field
  localparam int SH_W    = EXT_W + EXP_MAX;     // alignment shifter width
  localparam int NE_W    = EXP_W + 2;           // internal exponent width
  localparam logic [WORD_W-1:0] QUIET_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef struct packed {
    logic s1En;   // load alignment/add step
    logic s2En;   // load normalize/round/pack step
  } stepStrobes_t;
endpackage

// File: rtl/hp_addsub_ctrl.sv
module hp_addsub_ctrl
  import hp_addsub_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output stepStrobes_t stb,
  output logic         resValid
);
  logic stage1Full;
  logic stage2Full;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Full <= 1'b0;
      stage2Full <= 1'b0;
    end else begin
      stage1Full <= inValid;
      stage2Full <= stage1Full;
    end
  end

  always_comb begin
    stb.s1En = inValid;
    stb.s2En = stage1Full;
  end

  assign resValid = stage2Full;

  // R1: result strobe two edges after an accepted pair
  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##1 resValid);
endmodule

// File: rtl/hp_addsub_path.sv
module hp_addsub_path
  import hp_addsub_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  stepStrobes_t      stb,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              subSel,
  output logic [WORD_W-1:0] res
);
  // ---------------- step 1: unpack, order, align, add ----------------
  logic              signA, signB;
  logic [EXP_W-1:0]  expFieldA, expFieldB, effExpA, effExpB;
  logic [FRAC_W-1:0] fracA, fracB;
  logic [SIG_W-1:0]  sigA, sigB;
  logic              nanA, nanB, infA, infB;
  logic              aIsBig, effSub;
  logic [EXP_W-1:0]  bigExp, smallExp, expDiff;
  logic [SIG_W-1:0]  bigSig, smallSig;
  logic              bigSign;
  logic [SH_W-1:0]   shifted;
  logic [EXT_W-1:0]  bigExt, smallAligned;
  logic [EXT_W:0]    rawSum;
  logic              nanNow, infNow, infSignNow;

  always_comb begin
    signA     = opA[WORD_W-1];
    signB     = opB[WORD_W-1] ^ subSel;
    expFieldA = opA[WORD_W-2 -: EXP_W];
    expFieldB = opB[WORD_W-2 -: EXP_W];
    fracA     = opA[FRAC_W-1:0];
    fracB     = opB[FRAC_W-1:0];
    nanA      = (expFieldA == EXP_W'(EXP_MAX)) && (fracA != '0);
    nanB      = (expFieldB == EXP_W'(EXP_MAX)) && (fracB != '0);
    infA      = (expFieldA == EXP_W'(EXP_MAX)) && (fracA == '0);
    infB      = (expFieldB == EXP_W'(EXP_MAX)) && (fracB == '0);
    sigA      = {expFieldA != '0, fracA};
    sigB      = {expFieldB != '0, fracB};
    effExpA   = (expFieldA == '0) ? EXP_W'(1) : expFieldA;
    effExpB   = (expFieldB == '0) ? EXP_W'(1) : expFieldB;

    aIsBig    = {effExpA, sigA} >= {effExpB, sigB};
    bigExp    = aIsBig ? effExpA : effExpB;
    smallExp  = aIsBig ? effExpB : effExpA;
    bigSig    = aIsBig ? sigA : sigB;
    smallSig  = aIsBig ? sigB : sigA;
    bigSign   = aIsBig ? signA : signB;
    effSub    = signA ^ signB;
    expDiff   = bigExp - smallExp;

    shifted      = {smallSig, {(SH_W-SIG_W){1'b0}}} >> expDiff;
    smallAligned = {shifted[SH_W-1 -: EXT_W-1], |shifted[SH_W-EXT_W:0]};
    bigExt       = {bigSig, 3'b000};
    rawSum       = effSub ? ({1'b0, bigExt} - {1'b0, smallAligned})
                          : ({1'b0, bigExt} + {1'b0, smallAligned});

    nanNow     = nanA | nanB | (infA & infB & effSub);
    infNow     = infA | infB;
    infSignNow = infA ? signA : signB;
  end

  logic [EXT_W:0]   sumQ;
  logic [EXP_W-1:0] expQ;
  logic             signQ, subQ, nanQ, infQ, infSignQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumQ <= '0; expQ <= '0; signQ <= 1'b0; subQ <= 1'b0;
      nanQ <= 1'b0; infQ <= 1'b0; infSignQ <= 1'b0;
    end else if (stb.s1En) begin
      sumQ     <= rawSum;
      expQ     <= bigExp;
      signQ    <= bigSign;
      subQ     <= effSub;
      nanQ     <= nanNow;
      infQ     <= infNow;
      infSignQ <= infSignNow;
    end
  end

  // ---------------- step 2: normalize, round, pack ----------------
  function automatic logic [NE_W-1:0] leadZeros(input logic [EXT_W-1:0] v);
    logic [NE_W-1:0] n;
    n = NE_W'(EXT_W);
    for (int i = 0; i < EXT_W; i++)
      if (v[i]) n = NE_W'(EXT_W - 1 - i);
    return n;
  endfunction

  logic [NE_W-1:0]  lz, lzLimit, leftAmt, normExp, fieldExp;
  logic [EXT_W-1:0] normVal;
  logic [SIG_W-1:0] mant;
  logic             roundUp;
  logic [SIG_W:0]   rounded;
  logic [FRAC_W-1:0] fracOut;
  logic [WORD_W-1:0] packed_;

  always_comb begin
    lz      = leadZeros(sumQ[EXT_W-1:0]);
    lzLimit = NE_W'(expQ) - NE_W'(1);
    leftAmt = (lz < lzLimit) ? lz : lzLimit;
    if (sumQ[EXT_W]) begin
      normVal = {sumQ[EXT_W:2], sumQ[1] | sumQ[0]};
      normExp = NE_W'(expQ) + NE_W'(1);
    end else begin
      normVal = sumQ[EXT_W-1:0] << leftAmt;
      normExp = NE_W'(expQ) - leftAmt;
    end

    mant    = normVal[EXT_W-1:3];
    roundUp = normVal[2] & (normVal[1] | normVal[0] | mant[0]);
    rounded = {1'b0, mant} + (SIG_W+1)'(roundUp);

    if (rounded[SIG_W]) begin
      fieldExp = normExp + NE_W'(1);
      fracOut  = rounded[FRAC_W:1];
    end else begin
      fieldExp = rounded[FRAC_W] ? normExp : '0;
      fracOut  = rounded[FRAC_W-1:0];
    end

    if (nanQ)
      packed_ = QUIET_NAN;
    else if (infQ)
      packed_ = {infSignQ, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (sumQ == '0)
      packed_ = {signQ & ~subQ, {(WORD_W-1){1'b0}}};
    else if (fieldExp >= NE_W'(EXP_MAX))
      packed_ = {signQ, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else
      packed_ = {signQ, fieldExp[EXP_W-1:0], fracOut};
  end

  always_ff @(posedge clk) begin
    if (!rstN) res <= '0;
    else if (stb.s2En) res <= packed_;
  end

  // R3: after ordering, the subtrahend never exceeds the minuend
  p_sub_order_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.s1En && effSub) |-> ({1'b0, bigExt} >= {1'b0, smallAligned}));

  // R3: a left-normalized normal result carries its leading one in place
  p_norm_lead_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.s2En && !sumQ[EXT_W] && (sumQ != '0) && (normExp > NE_W'(1)))
      |-> normVal[EXT_W-1]);

  // R5: a rounding carry leaves an all-zero significand below it
  p_round_carry_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.s2En && rounded[SIG_W]) |-> (rounded[FRAC_W:0] == '0));

  // R7: NaN condition leaves the quiet NaN pattern in the result
  p_nan_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.s2En && nanQ) |=> (res == QUIET_NAN));

  // R6: exponent overflow of a finite result lands on infinity
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.s2En && !nanQ && !infQ && (sumQ != '0) && (fieldExp >= NE_W'(EXP_MAX)))
      |=> (res[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));
endmodule

// File: rtl/hp_addsub.sv
module hp_addsub
  import hp_addsub_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [15:0] opA,
  input  logic [15:0] opB,
  input  logic        subSel,
  output logic        resValid,
  output logic [15:0] res
);
  stepStrobes_t stb;

  hp_addsub_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .stb      (stb),
    .resValid (resValid)
  );

  hp_addsub_path u_path (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .opA    (opA),
    .opB    (opB),
    .subSel (subSel),
    .res    (res)
  );
endmodule

// File: tb/hp_addsub_bench.sv
`timescale 1ns/1ps
module hp_addsub_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic        subSel = 1'b0;
  logic        resValid;
  logic [15:0] res;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  hp_addsub u_hp_addsub (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .subSel(subSel), .resValid(resValid), .res(res)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] a, input logic [15:0] b, input logic s,
                      input logic [15:0] exp, input string tag);
    @(negedge clk);
    inValid = 1'b1; opA = a; opB = b; subSel = s;
    expQ.push_back(exp);
    tagQ.push_back(tag);
  endtask

  // monitor: pops expected results as the design produces them
  always @(negedge clk) begin
    if (rstN && resValid) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R1: unexpected result 0x%04h, expected none", res);
      end else begin
        automatic logic [15:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(t, res, e);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset valid", {15'b0, resValid}, 16'h0000);
    check("R1 reset result", res, 16'h0000);

    // R1: latency of exactly two edges
    send(16'h3C00, 16'h3C00, 1'b0, 16'h4000, "R2 1+1");
    @(negedge clk);
    inValid = 1'b0;
    check("R1 not early", {15'b0, resValid}, 16'h0000);
    @(negedge clk);
    check("R1 on time", {15'b0, resValid}, 16'h0001);

    // back-to-back stream
    send(16'h3E00, 16'h3C00, 1'b0, 16'h4100, "R2 1.5+1");
    send(16'h3C00, 16'h3BFF, 1'b1, 16'h1000, "R3 left normalize");
    send(16'h3C00, 16'h1000, 1'b0, 16'h3C00, "R4 tie to even down");
    send(16'h3C01, 16'h1000, 1'b0, 16'h3C02, "R4 tie to even up");
    send(16'h3FFF, 16'h1000, 1'b0, 16'h4000, "R5 round carry");
    send(16'h7BFF, 16'h7BFF, 1'b0, 16'h7C00, "R6 overflow pos");
    send(16'hFBFF, 16'hFBFF, 1'b0, 16'hFC00, "R6 overflow neg");
    send(16'h7C01, 16'h3C00, 1'b0, 16'h7E00, "R7 nan operand");
    send(16'h3C00, 16'h7E55, 1'b1, 16'h7E00, "R7 nan second");
    send(16'h7C00, 16'h7C00, 1'b1, 16'h7E00, "R7 inf minus inf");
    send(16'h7C00, 16'hFC00, 1'b0, 16'h7E00, "R7 inf plus neg inf");
    send(16'h7C00, 16'h3C00, 1'b0, 16'h7C00, "R8 inf plus finite");
    send(16'h3C00, 16'hFC00, 1'b0, 16'hFC00, "R8 finite plus neg inf");
    send(16'h3C00, 16'h7C00, 1'b1, 16'hFC00, "R8 finite minus inf");
    send(16'h3C00, 16'h3C00, 1'b1, 16'h0000, "R9 cancel sub");
    send(16'h4000, 16'hC000, 1'b0, 16'h0000, "R9 cancel add");
    send(16'h8000, 16'h8000, 1'b0, 16'h8000, "R9 neg zeros");
    send(16'h0001, 16'h0001, 1'b0, 16'h0002, "R10 denorm sum");
    send(16'h0400, 16'h0001, 1'b1, 16'h03FF, "R10 to denorm");
    send(16'h0200, 16'h0200, 1'b0, 16'h0400, "R10 denorm to normal");
    send(16'h3C00, 16'hBC00, 1'b1, 16'h4000, "R11 sub of negative");
    send(16'h3C00, 16'hC000, 1'b0, 16'hBC00, "R12 larger sign wins");
    send(16'hC000, 16'h3C00, 1'b0, 16'hBC00, "R12 larger sign first");
    @(negedge clk);
    inValid = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 all results returned", 16'(expQ.size()), 16'h0000);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1: watchdog expired, got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule